// File: doc/BRIEF.md
# Phase-Offset PWM Output Channel

This block turns a shared free-running period counter into one pulse-width-modulated output level. Two programmable compare points set the count at which the pulse rises and the count at which it falls. Because the two points are independent, a pulse can begin at any phase of the period. When the fall point is numerically below the rise point, the pulse wraps through the end of the period. Several channels fed by the same counter can therefore spread their rising edges, for example by giving channel k a rise point of k × 256. The high time is then (fall − rise) mod 2^CNT_W counts.

The compare points come from holding registers, and these are refreshed only at the period boundary, so a change never cuts a pulse short or adds a stray one mid-period. Three overrides sit above the compare result. Sleep, then a force-low flag, then a force-high flag decide the level before the window does. An inversion bit is applied after every other decision. The output is registered and follows the counter value with one clock of latency.

Top module: `pwm_phase_channel`

## Requirements
- R1: With rise point A below fall point B, flags and sleep clear, and invert clear, the pre-inversion level for counter value c is high exactly when A <= c < B.
- R2: With fall point B below rise point A, the level for c is high when c >= A or c < B, so one full period holds (B − A) mod 2^CNT_W high counts.
- R3: With equal rise and fall points and no flag set, the level stays low for the whole period.
- R4: The force-low flag drives the pre-inversion level low whatever the force-high flag and the compare points hold.
- R5: The force-high flag drives the pre-inversion level high when sleep and force-low are clear.
- R6: Sleep holds the pre-inversion level low, above every flag and compare result.
- R7: With the invert bit set, pwm_o is the complement of the level given by R1 to R6, sleep and force-low included.
- R8: New rise and fall values are captured on the clock edge at which cnt_i equals 2^CNT_W − 1 and apply from counter value 0 onward. Values that change at any other point leave the current period's waveform unchanged.
- R9: During reset pwm_o is 0, and both held compare points are 0.
- R10: pwm_o reflects the cnt_i value, flags, sleep and invert sampled at the previous rising clock edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared period counter value |
| on_cnt_i | input | CNT_W | Requested rise point |
| off_cnt_i | input | CNT_W | Requested fall point |
| full_on_i | input | 1 | Force level high (below force-low) |
| full_off_i | input | 1 | Force level low (below sleep only) |
| invert_i | input | 1 | Invert final output |
| sleep_i | input | 1 | Hold level inactive (low before inversion) |
| pwm_o | output | 1 | Registered PWM output |

## Verification
A held compare point that goes wrong, or one loaded at the wrong moment, shows as a high time in a period that differs from the programmed difference. A wrong edge count also shows it, and it appears within one period of the fault. A mid-period load shows sooner, as an edge at an unrequested count on the very next cycle. A wrong priority between sleep, force-low and force-high is visible at pwm_o one clock after the conflicting inputs are applied. A reference model compares every cycle, so a single misplaced edge is caught at the cycle it occurs.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
   // Which source decides the pre-inversion level
   typedef enum logic [1:0] {
      SRC_WINDOW  = 2'd0,
      SRC_PIN_LO  = 2'd1,
      SRC_PIN_HI  = 2'd2
   } lvl_src_e;
endpackage

// File: rtl/pwmch_shadow.sv
module pwmch_shadow #(
   parameter int CNT_W     = 12,
   parameter bit SYNC_LOAD = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] rise_i,
   input  logic [CNT_W-1:0] fall_i,
   output logic [CNT_W-1:0] rise_q,
   output logic [CNT_W-1:0] fall_q
);
   localparam logic [CNT_W-1:0] CntLast = '1;

   logic load_en;

   generate
      if (SYNC_LOAD) begin : g_wrap_load
         assign load_en = (cnt_i == CntLast);
      end else begin : g_free_load
         assign load_en = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_q <= '0;
         fall_q <= '0;
      end else if (load_en) begin
         rise_q <= rise_i;
         fall_q <= fall_i;
      end
   end

   generate
      if (SYNC_LOAD) begin : g_hold_chk
         // R8: held points only move across the period boundary
         p_hold_midperiod_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cnt_i != CntLast) |=> ($stable(rise_q) && $stable(fall_q)))
            else $error("held compare points changed mid-period");
      end
   endgenerate
endmodule

// File: rtl/pwmch_window.sv
module pwmch_window #(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] rise_i,
   input  logic [CNT_W-1:0] fall_i,
   output logic             hi_o
);
   logic past_rise, before_fall;

   assign past_rise   = (cnt_i >= rise_i);
   assign before_fall = (cnt_i <  fall_i);

   always_comb begin
      if (rise_i < fall_i)      hi_o = past_rise && before_fall;   // plain window
      else if (fall_i < rise_i) hi_o = past_rise || before_fall;   // wraps boundary
      else                      hi_o = 1'b0;                       // zero width
   end
endmodule

// File: rtl/pwmch_prio.sv
module pwmch_prio
   import pwmch_pkg::*;
(
   input  logic     sleep_i,
   input  logic     force_lo_i,
   input  logic     force_hi_i,
   output lvl_src_e src_o
);
   always_comb begin
      if (sleep_i || force_lo_i) src_o = SRC_PIN_LO;
      else if (force_hi_i)       src_o = SRC_PIN_HI;
      else                       src_o = SRC_WINDOW;
   end
endmodule

// File: rtl/pwm_phase_channel.sv
module pwm_phase_channel
   import pwmch_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter bit SYNC_LOAD = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] on_cnt_i,
   input  logic [CNT_W-1:0] off_cnt_i,
   input  logic             full_on_i,
   input  logic             full_off_i,
   input  logic             invert_i,
   input  logic             sleep_i,
   output logic             pwm_o
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("CNT_W must lie in 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] act_rise, act_fall;
   logic             win_hi, level, pwm_d;
   lvl_src_e         src;

   pwmch_shadow #(.CNT_W(CNT_W), .SYNC_LOAD(SYNC_LOAD)) u_shadow (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt_i),
      .rise_i (on_cnt_i),
      .fall_i (off_cnt_i),
      .rise_q (act_rise),
      .fall_q (act_fall)
   );

   pwmch_window #(.CNT_W(CNT_W)) u_window (
      .cnt_i  (cnt_i),
      .rise_i (act_rise),
      .fall_i (act_fall),
      .hi_o   (win_hi)
   );

   pwmch_prio u_prio (
      .sleep_i    (sleep_i),
      .force_lo_i (full_off_i),
      .force_hi_i (full_on_i),
      .src_o      (src)
   );

   always_comb begin
      unique case (src)
         SRC_PIN_LO: level = 1'b0;
         SRC_PIN_HI: level = 1'b1;
         default:    level = win_hi;
      endcase
      pwm_d = level ^ invert_i;   // inversion after all priority
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pwm_o <= 1'b0;
      else         pwm_o <= pwm_d;
   end

   logic quiet;
   assign quiet = !sleep_i && !full_off_i && !full_on_i;

   p_force_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_off_i |=> (pwm_o == $past(invert_i)))
      else $error("force-low not honoured");

   p_force_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_on_i && !full_off_i && !sleep_i) |=> (pwm_o == !$past(invert_i)))
      else $error("force-high not honoured");

   p_sleep_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i |=> (pwm_o == $past(invert_i)))
      else $error("sleep did not hold inactive level");

   p_equal_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && act_rise == act_fall) |=> (pwm_o == $past(invert_i)))
      else $error("equal points produced a pulse");

   p_rise_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && act_rise < act_fall && cnt_i == act_rise) |=> (pwm_o == !$past(invert_i)))
      else $error("no high level at rise point");

   p_wrap_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && act_fall < act_rise && cnt_i < act_fall) |=> (pwm_o == !$past(invert_i)))
      else $error("wrapped pulse missing at period start");

   p_fall_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && act_rise != act_fall && cnt_i == act_fall) |=> (pwm_o == $past(invert_i)))
      else $error("level not low at fall point");
endmodule

// File: tb/pwm_phase_channel_tb.sv
module pwm_phase_channel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W   = 12;
   localparam int PER = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt = '0, on_c = '0, off_c = '0;
   logic         f_on = 1'b0, f_off = 1'b0, inv = 1'b0, slp = 1'b0;
   logic         pwm;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_phase_channel #(.CNT_W(W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .on_cnt_i(on_c), .off_cnt_i(off_c),
      .full_on_i(f_on), .full_off_i(f_off), .invert_i(inv), .sleep_i(slp), .pwm_o(pwm)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int    m_rise = 0, m_fall = 0;
   bit    m_exp  = 1'b0;
   bit    m_live = 1'b0;
   string m_tag  = "R9";

   always @(posedge clk) begin
      int c, lvl;
      string t;
      c = int'(cnt);
      if (!rst_n) begin
         m_rise <= 0; m_fall <= 0; m_exp <= 1'b0; m_tag <= "R9";
      end else begin
         if (slp)        begin lvl = 0; t = "R6"; end
         else if (f_off) begin lvl = 0; t = "R4"; end
         else if (f_on)  begin lvl = 1; t = "R5"; end
         else if (m_rise == m_fall) begin lvl = 0; t = "R3"; end
         else if (m_rise < m_fall) begin
            lvl = (c >= m_rise && c < m_fall) ? 1 : 0; t = "R1";
         end else begin
            lvl = (c >= m_rise || c < m_fall) ? 1 : 0; t = "R2";
         end
         if (inv) t = {t, "/R7"};
         m_exp <= (lvl != 0) ^ inv;
         m_tag <= {t, "/R10"};
         if (c == PER - 1) begin          // R8 capture at period end
            m_rise <= int'(on_c);
            m_fall <= int'(off_c);
         end
      end
      m_live <= 1'b1;
   end

   always @(negedge clk) begin
      if (m_live && !done) check(m_tag, int'(pwm), int'(m_exp), "per-cycle compare");
   end

   // ---------------- stimulus helpers ----------------
   // Steps cnt through 0..PER-1; optionally changes points at step chg_at.
   task automatic run_period(input int chg_at, input int n_on, input int n_off,
                             output int highs);
      highs = 0;
      for (int c = 0; c < PER; c++) begin
         if (c == chg_at) begin on_c = W'(n_on); off_c = W'(n_off); end
         cnt = W'(c);
         @(negedge clk);
         if (pwm) highs++;
      end
   endtask

   task automatic program_and_measure(input int n_on, input int n_off, output int highs);
      int dummy;
      run_period(0, n_on, n_off, dummy);   // values captured at end of this period
      run_period(-1, 0, 0, highs);
   endtask

   initial begin
      #(CLK_PERIOD * 300000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int h;
      @(negedge clk); @(negedge clk);
      check("R9", int'(pwm), 0, "output during reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 plain window
      program_and_measure(100, 300, h);
      check("R1", h, 200, "high count, rise below fall");

      // R10 single register stage: drive exact points
      cnt = W'(99);  @(negedge clk); check("R10", int'(pwm), 0, "count 99");
      cnt = W'(100); @(negedge clk); check("R10", int'(pwm), 1, "count 100");
      cnt = W'(299); @(negedge clk); check("R1",  int'(pwm), 1, "count 299");
      cnt = W'(300); @(negedge clk); check("R1",  int'(pwm), 0, "count 300");

      // R2 wrapped pulse, staggered rise at 15*256
      program_and_measure(3840, 244, h);
      check("R2", h, 500, "high count, wrapped pulse");
      cnt = W'(0);   @(negedge clk); check("R2", int'(pwm), 1, "count 0 inside wrap");
      cnt = W'(244); @(negedge clk); check("R2", int'(pwm), 0, "count 244 after fall");

      // R3 equal points
      program_and_measure(777, 777, h);
      check("R3", h, 0, "equal points high count");

      // R8 mid-period change is held off until the boundary
      program_and_measure(100, 300, h);
      run_period(50, 1000, 1100, h);
      check("R8", h, 200, "period with mid-period change keeps old window");
      run_period(-1, 0, 0, h);
      check("R8", h, 100, "next period uses new window");

      // R5 / R4 priority
      f_on = 1'b1;
      run_period(-1, 0, 0, h);
      check("R5", h, PER, "force-high full period");
      f_off = 1'b1;
      run_period(-1, 0, 0, h);
      check("R4", h, 0, "force-low beats force-high");
      f_off = 1'b0;

      // R6 sleep above force-high
      slp = 1'b1;
      run_period(-1, 0, 0, h);
      check("R6", h, 0, "sleep holds low despite force-high");

      // R7 inversion after priority
      inv = 1'b1;
      run_period(-1, 0, 0, h);
      check("R7", h, PER, "inverted sleep level");
      slp = 1'b0; f_on = 1'b0;
      run_period(-1, 0, 0, h);
      check("R7", h, PER - 100, "inverted compare window");
      inv = 1'b0;

      // R9 reset again clears held points
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", int'(pwm), 0, "output in mid-run reset");
      rst_n = 1'b1;
      run_period(-1, 0, 0, h);
      check("R9", h, 0, "held points cleared by reset");

      finish_run();
   end
endmodule